// File: doc/BRIEF.md
# Block Copy Sequencer

This block copies a run of bytes from one place in a 24-bit address space to another, one byte per iteration. Software loads a starting source index and destination index, a 16-bit count, and the two bank bytes taken from an instruction's operand field. A direction select chooses whether the indexes climb or descend. An index-width flag chooses whether the indexes are full 16-bit values or 8-bit values whose upper byte is zero. After `start`, the block reads a byte from the source and then writes it to the destination. It then steps both indexes and decrements the count. When the count passes below zero, it reports completion.

Memory is outside the block and is reached through two request/ready ports, one for reading and one for writing. A request stays asserted, with a steady address, until the matching ready is seen high at a clock edge. At that edge the transfer takes place. The read data is sampled at the edge that completes the read.

The controller has four states:
- `ST_IDLE` waits for `start`. When `start` is seen it loads the operands and moves to `ST_READ`.
- `ST_READ` drives the read request. When `rd_ready` is high it captures the data and moves to `ST_WRITE`.
- `ST_WRITE` drives the write request. When `wr_ready` is high it steps the indexes and the count. It then goes back to `ST_READ`, or to `ST_DONE` if that was the last byte.
- `ST_DONE` raises `done` for one cycle and returns to `ST_IDLE`.

Top module: `bmv_sequencer`

## Requirements
- R1: After reset, `rd_req`, `wr_req` and `done` are low, and `x_out`, `y_out` and `cnt_out` read zero.
- R2: The read address is {`op_byte2`, X} and the write address is {`op_byte1`, Y}. Here `op_byte2` is the second operand byte and `op_byte1` is the first. X and Y are the current working indexes.
- R3: When `idx8` is 1 at start, the upper byte of X and Y is forced to zero, and stepping wraps within the low 8 bits. When `idx8` is 0, the indexes are full 16-bit values.
- R4: Exactly `cnt_in` + 1 bytes are moved. The count falls by one after each write, and `cnt_out` ends at 0xFFFF.
- R5: With `dir_dec` = 0, X and Y each rise by one after every write, wrapping from 0xFFFF to 0x0000. The bank bytes never change during a move.
- R6: With `dir_dec` = 1, X and Y each fall by one after every write, wrapping from 0x0000 to 0xFFFF.
- R7: Each write is issued only after its read has completed. The write data equals the byte returned by that read. `rd_req` and `wr_req` are never high together.
- R8: A request stays high, with its address and data unchanged, until its ready is seen.
- R9: `done` is high for exactly one cycle, in the cycle after the last write completes. In that cycle, `x_out`, `y_out` and `cnt_out` show the final values, and no request is active.
- R10: `start` is ignored while a move is in progress. Operand changes at that time have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a move (sampled in idle only) |
| dir_dec | input | 1 | 1 = indexes descend, 0 = ascend |
| idx8 | input | 1 | 1 = 8-bit indexes with zero upper byte |
| op_byte1 | input | 8 | First operand byte: destination bank |
| op_byte2 | input | 8 | Second operand byte: source bank |
| x_in | input | 16 | Starting source index |
| y_in | input | 16 | Starting destination index |
| cnt_in | input | 16 | Byte count minus one |
| rd_req | output | 1 | Read request |
| rd_addr | output | 24 | Read address |
| rd_ready | input | 1 | Read completes at this edge |
| rd_data | input | 8 | Read data, valid with rd_ready |
| wr_req | output | 1 | Write request |
| wr_addr | output | 24 | Write address |
| wr_data | output | 8 | Write data |
| wr_ready | input | 1 | Write completes at this edge |
| x_out | output | 16 | Working source index |
| y_out | output | 16 | Working destination index |
| cnt_out | output | 16 | Working count |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situations to reach from the ports are index wrap-around and long stalls that fall in the middle of a byte. Index wrap-around means the 16-bit boundary in each direction, and the 8-bit boundary when `idx8` is set.

Directed moves start the indexes a few steps short of each boundary. The ready inputs are withheld at random cycles, so that some requests wait several cycles before they complete.

A `start` pulse with different operands is injected in the middle of a move. The bench then confirms that the addresses, the data and the final values still match the original request.

// File: rtl/bmv_pkg.sv
package bmv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } bmv_state_t;

endpackage

// File: rtl/bmv_index_step.sv
module bmv_index_step #(
    parameter int W  = 16,
    parameter int NW = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         narrow,
    input  logic         dec,
    input  logic         advance,
    output logic [W-1:0] value
);
    localparam int HW = W - NW;
    localparam logic [W-1:0]  ONE_W = {{(W-1){1'b0}}, 1'b1};
    localparam logic [NW-1:0] ONE_N = {{(NW-1){1'b0}}, 1'b1};

    logic          narrow_q;
    logic          dec_q;
    logic [W-1:0]  wide_nxt;
    logic [NW-1:0] low_nxt;
    logic [W-1:0]  nxt;

    always_comb begin
        wide_nxt = dec_q ? (value - ONE_W) : (value + ONE_W);
        low_nxt  = dec_q ? (value[NW-1:0] - ONE_N) : (value[NW-1:0] + ONE_N);
        nxt      = narrow_q ? {{HW{1'b0}}, low_nxt} : wide_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value    <= '0;
            narrow_q <= 1'b0;
            dec_q    <= 1'b0;
        end else if (load) begin
            value    <= narrow ? {{HW{1'b0}}, init[NW-1:0]} : init;
            narrow_q <= narrow;
            dec_q    <= dec;
        end else if (advance) begin
            value    <= nxt;
        end
    end
endmodule

// File: rtl/bmv_counter.sv
module bmv_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] init,
    input  logic         advance,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] ONE_W = {{(W-1){1'b0}}, 1'b1};

    assign last = (count == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= init;
        end else if (advance) begin
            count <= count - ONE_W;
        end
    end
endmodule

// File: rtl/bmv_fsm.sv
module bmv_fsm
    import bmv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_ready,
    input  logic wr_ready,
    input  logic last,
    output logic rd_req,
    output logic wr_req,
    output logic done,
    output logic load,
    output logic capture,
    output logic advance
);
    bmv_state_t state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (start)    state_nxt = ST_READ;
            ST_READ:  if (rd_ready) state_nxt = ST_WRITE;
            ST_WRITE: if (wr_ready) state_nxt = last ? ST_DONE : ST_READ;
            ST_DONE:                state_nxt = ST_IDLE;
            default:                state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req  = 1'b0;
        wr_req  = 1'b0;
        done    = 1'b0;
        load    = 1'b0;
        capture = 1'b0;
        advance = 1'b0;
        unique case (state)
            ST_IDLE:  load = start;
            ST_READ: begin
                rd_req  = 1'b1;
                capture = rd_ready;
            end
            ST_WRITE: begin
                wr_req  = 1'b1;
                advance = wr_ready;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/bmv_sequencer.sv
module bmv_sequencer #(
    parameter int IDX_W  = 16,
    parameter int NIDX_W = 8,
    parameter int BANK_W = 8,
    parameter int DATA_W = 8,
    localparam int ADDR_W = BANK_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_dec,
    input  logic              idx8,
    input  logic [BANK_W-1:0] op_byte1,
    input  logic [BANK_W-1:0] op_byte2,
    input  logic [IDX_W-1:0]  x_in,
    input  logic [IDX_W-1:0]  y_in,
    input  logic [IDX_W-1:0]  cnt_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ready,
    input  logic [DATA_W-1:0] rd_data,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    input  logic              wr_ready,
    output logic [IDX_W-1:0]  x_out,
    output logic [IDX_W-1:0]  y_out,
    output logic [IDX_W-1:0]  cnt_out,
    output logic              done
);
    logic load, capture, advance, last;
    logic [BANK_W-1:0] src_bank, dst_bank;
    logic [DATA_W-1:0] data_q;
    logic [IDX_W-1:0]  idx_init [2];
    logic [IDX_W-1:0]  idx_val  [2];

    assign idx_init[0] = x_in;
    assign idx_init[1] = y_in;

    bmv_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_ready (rd_ready),
        .wr_ready (wr_ready),
        .last     (last),
        .rd_req   (rd_req),
        .wr_req   (wr_req),
        .done     (done),
        .load     (load),
        .capture  (capture),
        .advance  (advance)
    );

    for (genvar g = 0; g < 2; g++) begin : g_idx
        bmv_index_step #(.W(IDX_W), .NW(NIDX_W)) u_step (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (load),
            .init    (idx_init[g]),
            .narrow  (idx8),
            .dec     (dir_dec),
            .advance (advance),
            .value   (idx_val[g])
        );
    end

    bmv_counter #(.W(IDX_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .init    (cnt_in),
        .advance (advance),
        .count   (cnt_out),
        .last    (last)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_bank <= '0;
            dst_bank <= '0;
        end else if (load) begin
            src_bank <= op_byte2;
            dst_bank <= op_byte1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (capture) begin
            data_q <= rd_data;
        end
    end

    assign x_out   = idx_val[0];
    assign y_out   = idx_val[1];
    assign rd_addr = {src_bank, idx_val[0]};
    assign wr_addr = {dst_bank, idx_val[1]};
    assign wr_data = data_q;
endmodule

// File: rtl/bmv_seq_checker.sv
module bmv_seq_checker #(
    parameter int IDX_W  = 16,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ready,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              wr_ready,
    input logic [IDX_W-1:0]  cnt_out,
    input logic              done
);
    localparam logic [IDX_W-1:0] ONE_W = {{(IDX_W-1){1'b0}}, 1'b1};

    p_one_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && wr_req));

    p_rd_then_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ready) |=> (wr_req && !rd_req));

    p_rd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ready) |=> (rd_req && $stable(rd_addr)));

    p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ready) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready) |=> (cnt_out == $past(cnt_out) - ONE_W));

    p_done_after_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ready && cnt_out == '0) |=> done);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_req && !wr_req && cnt_out == '1));
endmodule

bind bmv_sequencer bmv_seq_checker #(
    .IDX_W  (IDX_W),
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .wr_req   (wr_req),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_ready (wr_ready),
    .cnt_out  (cnt_out),
    .done     (done)
);

// File: tb/tb_bmv_sequencer.sv
module tb_bmv_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_dec = 1'b0;
    logic        idx8 = 1'b0;
    logic [7:0]  op_byte1 = '0;
    logic [7:0]  op_byte2 = '0;
    logic [15:0] x_in = '0, y_in = '0, cnt_in = '0;
    logic        rd_req, wr_req, done;
    logic [23:0] rd_addr, wr_addr;
    logic        rd_ready = 1'b0, wr_ready = 1'b0;
    logic [7:0]  rd_data, wr_data;
    logic [15:0] x_out, y_out, cnt_out;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h5A;
    endfunction

    function automatic logic [15:0] stepf(input logic [15:0] v, input logic dec, input logic n8);
        logic [15:0] w;
        logic [7:0]  l;
        w = dec ? v - 16'd1 : v + 16'd1;
        l = dec ? v[7:0] - 8'd1 : v[7:0] + 8'd1;
        return n8 ? {8'h00, l} : w;
    endfunction

    assign rd_data = memf(rd_addr);

    bmv_sequencer dut (
        .clk(clk), .rst_n(rst_n), .start(start), .dir_dec(dir_dec), .idx8(idx8),
        .op_byte1(op_byte1), .op_byte2(op_byte2), .x_in(x_in), .y_in(y_in),
        .cnt_in(cnt_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_data(rd_data), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_ready(wr_ready), .x_out(x_out), .y_out(y_out), .cnt_out(cnt_out),
        .done(done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            finish_run();
        end
    end

    // One move: start, answer requests with random stalls, check every transfer.
    task automatic run_move(input logic [7:0] b1, input logic [7:0] b2,
                            input logic [15:0] xs, input logic [15:0] ys,
                            input logic [15:0] cn, input logic dec, input logic n8,
                            input int stall_pct, input bit poke_start);
        logic [15:0] ex, ey;
        int   bytes;
        bit   want_wr;
        bit   fin;
        int   guard;
        ex = n8 ? {8'h00, xs[7:0]} : xs;
        ey = n8 ? {8'h00, ys[7:0]} : ys;
        bytes = 0; want_wr = 0; fin = 0; guard = 0;
        @(negedge clk);
        op_byte1 = b1; op_byte2 = b2; x_in = xs; y_in = ys; cnt_in = cn;
        dir_dec = dec; idx8 = n8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && guard < 20000) begin
            guard++;
            rd_ready = 1'b0;
            wr_ready = 1'b0;
            if (poke_start && bytes == 1 && rd_req) begin
                // R10: a second start in mid-move with different operands
                start = 1'b1; op_byte1 = ~b1; op_byte2 = ~b2;
                x_in = ~xs; y_in = ~ys; cnt_in = 16'h0003; dir_dec = ~dec; idx8 = ~n8;
            end else begin
                start = 1'b0;
            end
            if (done) begin
                chk(bytes == int'(cn) + 1, "R4 byte count", bytes, int'(cn) + 1);
                chk(cnt_out == 16'hFFFF, "R4 final count", cnt_out, 16'hFFFF);
                chk(x_out == ex, "R5/R6 final X", x_out, ex);
                chk(y_out == ey, "R5/R6 final Y", y_out, ey);
                chk(!rd_req && !wr_req, "R9 quiet at done", {rd_req, wr_req}, 0);
                if (poke_start)
                    chk(bytes == int'(cn) + 1, "R10 start ignored", bytes, int'(cn) + 1);
                fin = 1;
            end else if (rd_req && wr_req) begin
                chk(0, "R7 both requests", 2'b11, 2'b01);
            end else if (rd_req) begin
                if (want_wr) chk(0, "R7 read before write", 1, 0);
                if (($urandom % 100) >= stall_pct) begin
                    chk(rd_addr == {b2, ex}, "R2 read address", rd_addr, {b2, ex});
                    rd_ready = 1'b1;
                    want_wr = 1;
                end
            end else if (wr_req) begin
                if (!want_wr) chk(0, "R7 write before read", 0, 1);
                if (($urandom % 100) >= stall_pct) begin
                    chk(wr_addr == {b1, ey}, "R2 write address", wr_addr, {b1, ey});
                    chk(wr_data == memf({b2, ex}), "R7 write data", wr_data, memf({b2, ex}));
                    wr_ready = 1'b1;
                    want_wr = 0;
                    bytes++;
                    ex = stepf(ex, dec, n8);
                    ey = stepf(ey, dec, n8);
                end
            end
            @(negedge clk);
        end
        start = 1'b0;
        rd_ready = 1'b0;
        wr_ready = 1'b0;
        chk(fin == 1, "R9 done seen", fin, 1);
        chk(done == 1'b0, "R9 done one cycle", done, 0);
        chk(cnt_out == 16'hFFFF && x_out == ex, "R9 final values held", {cnt_out, x_out},
            {16'hFFFF, ex});
    endtask

    initial begin
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        chk(!rd_req && !wr_req && !done, "R1 reset outputs", {rd_req, wr_req, done}, 0);
        chk(x_out == 0 && y_out == 0 && cnt_out == 0, "R1 reset regs",
            {x_out, y_out}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rd_req && !wr_req && !done, "R1 idle after reset", {rd_req, wr_req, done}, 0);

        // Directed corners
        run_move(8'h12, 8'h34, 16'h1000, 16'h2000, 16'h0000, 1'b0, 1'b0, 0, 0);  // R4 single byte
        run_move(8'hA1, 8'hB2, 16'hFFFE, 16'hFFFD, 16'h0004, 1'b0, 1'b0, 30, 0); // R5 wrap up
        run_move(8'h01, 8'h02, 16'h0001, 16'h0002, 16'h0004, 1'b1, 1'b0, 30, 0); // R6 wrap down
        run_move(8'h7E, 8'h7F, 16'hABFE, 16'hCDFD, 16'h0005, 1'b0, 1'b1, 40, 0); // R3 narrow up
        run_move(8'h55, 8'hAA, 16'h3401, 16'h5600, 16'h0003, 1'b1, 1'b1, 40, 0); // R3 narrow down
        run_move(8'h10, 8'h20, 16'h0100, 16'h8000, 16'h0006, 1'b0, 1'b0, 60, 1); // R10, R8 stalls
        run_move(8'hC3, 8'h3C, 16'h4000, 16'h4100, 16'h0101, 1'b0, 1'b0, 10, 0); // R4 long run

        // Random moves
        for (int i = 0; i < 40; i++) begin
            run_move(8'($urandom), 8'($urandom), 16'($urandom), 16'($urandom),
                     16'($urandom % 12), 1'($urandom), 1'($urandom),
                     int'($urandom % 70), 1'($urandom % 4 == 0));
        end
        finish_run();
    end
endmodule